// File: doc/BRIEF.md
# Opcode Decoder with Carry/Zero Flag ALU

This block is the execute slice of a small 8-bit processor. Each clock cycle it takes one 18-bit instruction word and decodes the opcode in its top five bits. It selects either a second register operand or the 8-bit constant held in the low byte, then computes the result. Only the subset of add, subtract, move and bitwise logic operations is handled. The surrounding core supplies the two operand values read from its 32-entry register file, plus the current carry and zero flags. It then writes back the registered result and flags that this block returns one cycle later.

Every operation in the subset writes its destination register and refreshes the zero flag. Only the eight arithmetic operations change carry. Addition reports carry-out, and subtraction reports a borrow when the result goes negative. Any opcode outside the subset leaves the register file and both flags untouched.

Top module: `op_flag_unit`

## Requirements
- R1: All outputs are registered. The values present at the ports reflect the inputs sampled at the previous rising clock edge.
- R2: The destination index output equals instruction bits 12:8. Opcode bit 13 (the opcode LSB) set selects the immediate in bits 7:0 as second operand, and the `opb` input is then ignored. Opcode bit 13 clear selects `opb`.
- R3: Opcodes 00100 (reg), 00101 (imm), 00110 (reg+carry), 00111 (imm+carry) produce `opa` plus the second operand, modulo 256. Carry becomes the carry-out of the 8-bit sum.
- R4: Opcodes 00000, 00001, 00010, 00011 (same form order) produce `opa` minus the second operand. Carry becomes 1 when the true difference is negative.
- R5: In the arithmetic group, opcode bit 14 set makes the operation also add (for add) or subtract (for subtract) the incoming carry flag. When bit 14 is clear, the carry input has no effect on the result.
- R6: Opcodes 01000/01001 copy the second operand, 01010/01011 AND it with `opa`, 01100/01101 OR it, and 01110/01111 XOR it.
- R7: Move and logic opcodes (01000 to 01111) pass the incoming carry flag to the carry output unchanged.
- R8: For every opcode in 00000 to 01111, write enable is 1 and the zero output is 1 exactly when all eight result bits are 0.
- R9: Opcodes 10000 to 11111 give write enable 0 and copy the incoming carry and zero flags to the outputs.
- R10: While the active-low reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn | input | 18 | Instruction word |
| opa | input | 8 | Value of the destination register (first operand) |
| opb | input | 8 | Value of the source register (second operand, register form) |
| cy_in | input | 1 | Current carry flag |
| zf_in | input | 1 | Current zero flag |
| dst_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Register write enable |
| res | output | 8 | Result to write back |
| cy_out | output | 1 | Next carry flag |
| zf_out | output | 1 | Next zero flag |

## Verification
The properties assume the caller drives known values on `insn`, `cy_in` and `zf_in` in every cycle after reset. They also assume the flags the caller feeds back come from a 1-bit source. The stimulus changes inputs only on falling edges and always drives every input with a defined value. A stimulus row carries a register-form instruction with bits 2:0 at zero. Immediate rows carry a deliberately conflicting `opb`, so operand selection can be seen at the result.

// File: rtl/ofu_pkg.sv
package ofu_pkg;
    localparam int DATA_W  = 8;
    localparam int REG_W   = 5;
    localparam int OPC_W   = 5;
    localparam int INSN_W  = OPC_W + REG_W + DATA_W;
    localparam int OPC_LSB = INSN_W - OPC_W;
    localparam int DST_LSB = DATA_W;

    typedef enum logic [1:0] {
        LG_MOVE = 2'd0,
        LG_AND  = 2'd1,
        LG_OR   = 2'd2,
        LG_XOR  = 2'd3
    } logic_sel_e;

    typedef struct packed {
        logic              known;
        logic              arith;
        logic              is_add;
        logic              use_cy;
        logic              use_imm;
        logic_sel_e        lsel;
        logic [REG_W-1:0]  dst;
        logic [DATA_W-1:0] imm;
    } dec_t;

    typedef struct packed {
        logic              we;
        logic [REG_W-1:0]  dst;
        logic [DATA_W-1:0] res;
        logic              cy;
        logic              zf;
    } out_t;
endpackage

// File: rtl/ofu_decode.sv
module ofu_decode
    import ofu_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);
    logic [OPC_W-1:0] opc;

    always_comb begin
        opc         = insn[INSN_W-1:OPC_LSB];
        dec.known   = ~opc[4];
        dec.arith   = ~opc[3];
        dec.is_add  = opc[2];
        dec.use_cy  = opc[1];
        dec.use_imm = opc[0];
        dec.lsel    = logic_sel_e'(opc[2:1]);
        dec.dst     = insn[DST_LSB+REG_W-1:DST_LSB];
        dec.imm     = insn[DATA_W-1:0];
    end
endmodule

// File: rtl/ofu_alu.sv
module ofu_alu
    import ofu_pkg::*;
(
    input  dec_t              dec,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              cy_in,
    output logic [DATA_W-1:0] res,
    output logic              cy_new
);
    logic [DATA_W-1:0] bval;
    logic [DATA_W:0]   wide;
    logic [DATA_W:0]   cin_w;

    always_comb begin
        bval  = dec.use_imm ? dec.imm : opb;
        cin_w = {{DATA_W{1'b0}}, dec.use_cy & cy_in};
        if (dec.is_add) begin
            wide = {1'b0, opa} + {1'b0, bval} + cin_w;
        end else begin
            wide = {1'b0, opa} - {1'b0, bval} - cin_w;
        end

        if (dec.arith) begin
            res    = wide[DATA_W-1:0];
            cy_new = wide[DATA_W];
        end else begin
            cy_new = cy_in;
            unique case (dec.lsel)
                LG_MOVE: res = bval;
                LG_AND:  res = opa & bval;
                LG_OR:   res = opa | bval;
                LG_XOR:  res = opa ^ bval;
                default: res = bval;
            endcase
        end
    end
endmodule

// File: rtl/op_flag_unit.sv
module op_flag_unit
    import ofu_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ofu_pkg::INSN_W-1:0] insn,
    input  logic [ofu_pkg::DATA_W-1:0] opa,
    input  logic [ofu_pkg::DATA_W-1:0] opb,
    input  logic                      cy_in,
    input  logic                      zf_in,
    output logic [ofu_pkg::REG_W-1:0]  dst_idx,
    output logic                      wr_en,
    output logic [ofu_pkg::DATA_W-1:0] res,
    output logic                      cy_out,
    output logic                      zf_out
);
    dec_t              dec;
    logic [DATA_W-1:0] alu_res;
    logic              alu_cy;
    out_t              out_d, out_q;
    logic              seen_q;

    ofu_decode u_dec (
        .insn (insn),
        .dec  (dec)
    );

    ofu_alu u_alu (
        .dec    (dec),
        .opa    (opa),
        .opb    (opb),
        .cy_in  (cy_in),
        .res    (alu_res),
        .cy_new (alu_cy)
    );

    always_comb begin
        out_d     = out_q;
        out_d.dst = dec.dst;
        out_d.res = alu_res;
        if (dec.known) begin
            out_d.we = 1'b1;
            out_d.cy = alu_cy;
            out_d.zf = (alu_res == '0);
        end else begin
            out_d.we = 1'b0;
            out_d.cy = cy_in;
            out_d.zf = zf_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            out_q  <= out_d;
            seen_q <= 1'b1;
        end
    end

    assign dst_idx = out_q.dst;
    assign wr_en   = out_q.we;
    assign res     = out_q.res;
    assign cy_out  = out_q.cy;
    assign zf_out  = out_q.zf;

    // R9: opcodes with the top bit set write nothing and keep both flags
    a_r9_foreign_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(insn[INSN_W-1])) |->
        (!wr_en && cy_out == $past(cy_in) && zf_out == $past(zf_in)));

    // R7: move and logic group passes carry through
    a_r7_logic_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(insn[INSN_W-1:INSN_W-2]) == 2'b01) |->
        (cy_out == $past(cy_in)));

    // R8: a write always carries a zero flag matching the written byte
    a_r8_zero_tracks_result: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (zf_out == (res == '0)));

    // R2: destination index follows the instruction field one cycle later
    a_r2_dst_follows: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (dst_idx == $past(insn[DST_LSB+REG_W-1:DST_LSB])));

    // R1: write enable reflects the opcode seen one edge earlier
    a_r1_we_latency: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (wr_en == !$past(insn[INSN_W-1])));
endmodule

// File: tb/op_flag_unit_test.sv
module op_flag_unit_test;
    localparam int NV = 18;

    typedef struct packed {
        logic [17:0] insn;
        logic [7:0]  a;
        logic [7:0]  b;
        logic        cy;
        logic        zf;
        logic        we;
        logic [7:0]  res;
        logic        ecy;
        logic        ezf;
    } vec_t;

    // insn = {opcode, rd, rb, 000} or {opcode, rd, imm}
    localparam vec_t TBL [NV] = '{
        '{ {5'b00100, 5'd1,  5'd2, 3'b0}, 8'h80, 8'h80, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1 }, // R3 add carry-out
        '{ {5'b00101, 5'd2,  8'h34},      8'h12, 8'hFF, 1'b1, 1'b0, 1'b1, 8'h46, 1'b0, 1'b0 }, // R3 R2 R5 addi ignores opb, cy
        '{ {5'b00110, 5'd3,  5'd4, 3'b0}, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1 }, // R5 addc
        '{ {5'b00111, 5'd4,  8'h0F},      8'h10, 8'h77, 1'b1, 1'b0, 1'b1, 8'h20, 1'b0, 1'b0 }, // R5 addic
        '{ {5'b00000, 5'd5,  5'd6, 3'b0}, 8'h05, 8'h07, 1'b0, 1'b1, 1'b1, 8'hFE, 1'b1, 1'b0 }, // R4 sub borrow
        '{ {5'b00001, 5'd6,  8'h07},      8'h07, 8'h01, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1 }, // R4 R5 subi
        '{ {5'b00010, 5'd7,  5'd8, 3'b0}, 8'h07, 8'h06, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1 }, // R5 subc
        '{ {5'b00011, 5'd8,  8'h00},      8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 8'hFF, 1'b1, 1'b0 }, // R5 subic borrow
        '{ {5'b01000, 5'd9,  5'd1, 3'b0}, 8'h5A, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1 }, // R6 R7 R8 mov zero
        '{ {5'b01001, 5'd10, 8'hA5},      8'h00, 8'h11, 1'b0, 1'b1, 1'b1, 8'hA5, 1'b0, 1'b0 }, // R6 movi
        '{ {5'b01010, 5'd11, 5'd2, 3'b0}, 8'hF0, 8'h0F, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1 }, // R6 and
        '{ {5'b01011, 5'd12, 8'h24},      8'h3C, 8'h00, 1'b0, 1'b0, 1'b1, 8'h24, 1'b0, 1'b0 }, // R6 andi
        '{ {5'b01100, 5'd13, 5'd3, 3'b0}, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1 }, // R6 or
        '{ {5'b01101, 5'd14, 8'h80},      8'h01, 8'h7E, 1'b0, 1'b0, 1'b1, 8'h81, 1'b0, 1'b0 }, // R6 ori
        '{ {5'b01110, 5'd15, 5'd4, 3'b0}, 8'hAA, 8'hAA, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1 }, // R6 xor
        '{ {5'b01111, 5'd31, 8'hFF},      8'hAA, 8'h00, 1'b0, 1'b1, 1'b1, 8'h55, 1'b0, 1'b0 }, // R6 xori
        '{ {5'b10000, 5'd16, 8'h00},      8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0 }, // R9
        '{ {5'b11111, 5'd17, 8'hFF},      8'hFF, 8'hFF, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1 }  // R9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] insn = '0;
    logic [7:0]  opa = '0, opb = '0;
    logic        cy_in = 1'b0, zf_in = 1'b0;
    logic [4:0]  dst_idx;
    logic        wr_en, cy_out, zf_out;
    logic [7:0]  res;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    op_flag_unit uut (
        .clk(clk), .rst_n(rst_n), .insn(insn), .opa(opa), .opb(opb),
        .cy_in(cy_in), .zf_in(zf_in), .dst_idx(dst_idx), .wr_en(wr_en),
        .res(res), .cy_out(cy_out), .zf_out(zf_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 we", wr_en, 0);
        check("R10 res", res, 0);
        check("R10 flags", {cy_out, zf_out, dst_idx}, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            insn = TBL[i].insn; opa = TBL[i].a; opb = TBL[i].b;
            cy_in = TBL[i].cy; zf_in = TBL[i].zf;
            @(negedge clk);
            check($sformatf("R1/R8/R9 we v%0d", i), wr_en, TBL[i].we);
            check($sformatf("R3/R4/R7/R9 cy v%0d", i), cy_out, TBL[i].ecy);
            check($sformatf("R8/R9 zf v%0d", i), zf_out, TBL[i].ezf);
            if (TBL[i].we) begin
                check($sformatf("R3/R4/R6 res v%0d", i), res, TBL[i].res);
                check($sformatf("R2 dst v%0d", i), dst_idx, TBL[i].insn[12:8]);
            end
        end

        // R5: with carry bit clear, incoming carry must not change sum
        insn = {5'b00100, 5'd20, 5'd1, 3'b0}; opa = 8'h01; opb = 8'h01; cy_in = 1'b1;
        @(negedge clk);
        check("R5 add ignores cy", res, 8'h02);
        check("R5 add carry out", cy_out, 0);

        // R1: output holds until the next edge after an input change
        insn = {5'b01001, 5'd21, 8'h3C}; cy_in = 1'b0;
        #5;
        check("R1 no early change", res, 8'h02);
        @(negedge clk);
        check("R1 registered", res, 8'h3C);

        // R10: reset mid-run clears outputs
        rst_n = 1'b0;
        #2;
        check("R10 async clear we", wr_en, 0);
        check("R10 async clear res", res, 0);
        @(negedge clk);
        check("R10 held", {cy_out, zf_out, dst_idx}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", res, 8'h3C);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule